// File: doc/BRIEF.md
# Legacy I/O Claim-Timing Decoder

This block sits on the target side of a PCI-style bus and decides, for every transaction it sees start, whether it claims that transaction and on which clock it raises its claim strobe. The low I/O window from 0000h to 03FFh can be decoded actively at a selectable speed. Two groups of disk-controller port addresses can each be excluded from that active decode. A separate window at 0480h–048Fh can be switched into active decode. Everything else falls back to a subtractive claim on the fourth clock, unless another agent claims first.

Clocks are counted from the transaction start: the cycle in which the start input is low is clock 1. The claim strobe is high for exactly the one cycle that is the selected claim clock. The active flag is high in that same cycle when the claim came from a positive decode. A forward flag pulses in the following cycle to hand the cycle on to the internal fabric. Active and subtractive claims are forwarded in the same way.

Top module: `legacy_claim_decoder`

## Requirements
- R1: After reset, and after any reset in the middle of a transaction, claim, active and forward outputs are low and no pending claim survives.
- R2: Only command codes 2h (I/O read) and 3h (I/O write) can be decoded actively; any other command is claimed subtractively on clock 4 whatever its address.
- R3: With speed field 2'b10, an I/O command to an address in 0000h–03FFh is claimed actively on clock 2.
- R4: With speed field 2'b01, an I/O command to the same window is claimed actively on clock 3.
- R5: With speed field 2'b00, or with the reserved value 2'b11, or for an address outside every active window, the claim is subtractive on clock 4 with the active flag low.
- R6: When the primary reject input is high, I/O addresses 01F0h–01F7h and 03F6h are claimed subtractively; neighbours such as 01F8h remain active, and with the input low these addresses are decoded actively.
- R7: When the secondary reject input is high, I/O addresses 0170h–0177h and 0376h are claimed subtractively; the primary reject input has no effect on them.
- R8: When the DMA-page enable is high, I/O addresses 0480h–048Fh are claimed actively on clock 2 whatever the speed field; with it low they are subtractive.
- R9: An external claim seen on clock 2 or clock 3 cancels a pending subtractive claim, so neither the claim strobe nor the forward flag appears; it has no effect on an active claim or when it arrives on clock 4.
- R10: The forward flag pulses once, in the cycle right after each claim strobe, and never without one.
- R11: A start that arrives while a claim is pending, or in the claim cycle itself, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_n | input | 1 | Low for one cycle marks the address clock of a new transaction |
| cmd | input | 4 | Bus command captured on the address clock |
| addr | input | ADDR_W | Address captured on the address clock |
| cfg_speed | input | 2 | Claim speed for the legacy window (00 sub, 01 slow, 10 medium, 11 reserved) |
| cfg_rej_pri | input | 1 | Exclude primary disk ports from active decode |
| cfg_rej_sec | input | 1 | Exclude secondary disk ports from active decode |
| cfg_dma_en | input | 1 | Enable active decode of the DMA page window |
| ext_claim | input | 1 | Another agent has claimed the current transaction |
| claim_o | output | 1 | One-cycle claim strobe on the chosen clock |
| claim_active_o | output | 1 | High with claim_o when the claim is positive |
| fwd_o | output | 1 | One-cycle forward-to-fabric pulse after a claim |

## Verification
Two events can land in one cycle: an external claim and this block's own subtractive deadline, or an external claim and a slow active claim still waiting. The bench raises the external claim on clock 2, 3 and 4 of subtractive transactions and on clock 2 of a slow active one. It judges by whether the strobe and forward pulse appear, and on which clock. A second overlap, a new start arriving while a claim is pending or in the claim cycle, is driven directly. The bench then checks that exactly one strobe follows.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  typedef enum logic [1:0] {
    SPD_SUB  = 2'b00,
    SPD_SLOW = 2'b01,
    SPD_MED  = 2'b10,
    SPD_RSVD = 2'b11
  } spd_e;

  localparam logic [3:0] CMD_IO_RD = 4'h2;
  localparam logic [3:0] CMD_IO_WR = 4'h3;

  typedef struct packed {
    logic       active;
    logic [2:0] clk_no;
  } decision_t;

endpackage

// File: rtl/lcd_range_hit.sv
module lcd_range_hit #(
  parameter int ADDR_W = 32,
  parameter logic [31:0] LO = 32'h0,
  parameter logic [31:0] HI = 32'h0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] LO_W = LO[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] HI_W = HI[ADDR_W-1:0];

  always_comb hit = (addr >= LO_W) && (addr <= HI_W);
endmodule

// File: rtl/lcd_addr_decode.sv
module lcd_addr_decode
  import lcd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEGACY_BITS = 10,
  parameter int SUB_CLK     = 4,
  parameter int SLOW_CLK    = 3,
  parameter int MED_CLK     = 2,
  parameter int DMA_CLK     = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        cmd,
  input  logic [1:0]        cfg_speed,
  input  logic              cfg_rej_pri,
  input  logic              cfg_rej_sec,
  input  logic              cfg_dma_en,
  output decision_t         dec
);
  // Disk-port exclusion groups: index 0 primary, 1 secondary.
  localparam logic [31:0] BLK_LO [2] = '{32'h01F0, 32'h0170};
  localparam logic [31:0] BLK_HI [2] = '{32'h01F7, 32'h0177};
  localparam logic [31:0] ONE_AD [2] = '{32'h03F6, 32'h0376};

  logic       is_io;
  logic       in_legacy;
  logic       dma_hit;
  logic [1:0] grp_hit;
  logic [1:0] grp_rej;

  always_comb begin
    is_io     = (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
    in_legacy = (addr[ADDR_W-1:LEGACY_BITS] == '0);
    grp_rej   = {cfg_rej_sec, cfg_rej_pri};
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp
    logic blk_hit;
    logic one_hit;
    lcd_range_hit #(.ADDR_W(ADDR_W), .LO(BLK_LO[g]), .HI(BLK_HI[g])) u_blk (
      .addr(addr), .hit(blk_hit));
    lcd_range_hit #(.ADDR_W(ADDR_W), .LO(ONE_AD[g]), .HI(ONE_AD[g])) u_one (
      .addr(addr), .hit(one_hit));
    always_comb grp_hit[g] = blk_hit | one_hit;
  end

  lcd_range_hit #(.ADDR_W(ADDR_W), .LO(32'h0480), .HI(32'h048F)) u_dma (
    .addr(addr), .hit(dma_hit));

  always_comb begin
    dec.active = 1'b0;
    dec.clk_no = 3'(SUB_CLK);
    if (is_io && cfg_dma_en && dma_hit) begin
      dec.active = 1'b1;
      dec.clk_no = 3'(DMA_CLK);
    end else if (is_io && in_legacy && ((grp_hit & grp_rej) == 2'b00)) begin
      case (spd_e'(cfg_speed))
        SPD_MED:  begin dec.active = 1'b1; dec.clk_no = 3'(MED_CLK);  end
        SPD_SLOW: begin dec.active = 1'b1; dec.clk_no = 3'(SLOW_CLK); end
        default:  begin dec.active = 1'b0; dec.clk_no = 3'(SUB_CLK);  end
      endcase
    end
  end
endmodule

// File: rtl/lcd_claim_timer.sv
module lcd_claim_timer
  import lcd_pkg::*;
#(
  parameter int SUB_CLK = 4,
  parameter int CNT_W   = $clog2(SUB_CLK + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  decision_t dec,
  input  logic      ext_claim,
  output logic      claim_o,
  output logic      active_o
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e              state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tgt_q;
  logic             act_pend;
  logic             claim_q;
  logic             act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      tgt_q    <= '0;
      act_pend <= 1'b0;
      claim_q  <= 1'b0;
      act_q    <= 1'b0;
    end else begin
      claim_q <= 1'b0;
      act_q   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start && !claim_q) begin
            if (dec.clk_no <= 3'd2) begin
              claim_q <= 1'b1;
              act_q   <= dec.active;
            end else begin
              state    <= ST_WAIT;
              cnt      <= CNT_W'(2);
              tgt_q    <= CNT_W'(dec.clk_no);
              act_pend <= dec.active;
            end
          end
        end
        ST_WAIT: begin
          if (ext_claim && !act_pend) begin
            state <= ST_IDLE;
          end else if (cnt + 1'b1 == tgt_q) begin
            claim_q <= 1'b1;
            act_q   <= act_pend;
            state   <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign claim_o  = claim_q;
  assign active_o = act_q;

  // R11: a claim strobe never lasts two cycles
  assert_single_strobe_R11: assert property (@(posedge clk) disable iff (rst)
    claim_q |=> !claim_q);
  // R3: the active flag only appears with a strobe
  assert_active_with_claim_R3: assert property (@(posedge clk) disable iff (rst)
    act_q |-> claim_q);
  // R5: waiting never overruns the target clock
  assert_wait_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> (cnt < tgt_q));
  // R9: an external claim while a subtractive claim waits drops it
  assert_ext_cancel_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && ext_claim && !act_pend) |=> (!claim_q && state == ST_IDLE));
endmodule

// File: rtl/legacy_claim_decoder.sv
module legacy_claim_decoder
  import lcd_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LEGACY_BITS = 10,
  parameter int SUB_CLK     = 4,
  parameter int SLOW_CLK    = 3,
  parameter int MED_CLK     = 2,
  parameter int DMA_CLK     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_n,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cfg_speed,
  input  logic              cfg_rej_pri,
  input  logic              cfg_rej_sec,
  input  logic              cfg_dma_en,
  input  logic              ext_claim,
  output logic              claim_o,
  output logic              claim_active_o,
  output logic              fwd_o
);
  decision_t dec;
  logic      fwd_q;

  lcd_addr_decode #(
    .ADDR_W(ADDR_W), .LEGACY_BITS(LEGACY_BITS), .SUB_CLK(SUB_CLK),
    .SLOW_CLK(SLOW_CLK), .MED_CLK(MED_CLK), .DMA_CLK(DMA_CLK)
  ) u_dec (
    .addr(addr), .cmd(cmd), .cfg_speed(cfg_speed), .cfg_rej_pri(cfg_rej_pri),
    .cfg_rej_sec(cfg_rej_sec), .cfg_dma_en(cfg_dma_en), .dec(dec));

  lcd_claim_timer #(.SUB_CLK(SUB_CLK)) u_tmr (
    .clk(clk), .rst(rst), .start(!start_n), .dec(dec), .ext_claim(ext_claim),
    .claim_o(claim_o), .active_o(claim_active_o));

  always_ff @(posedge clk) begin
    if (rst) fwd_q <= 1'b0;
    else     fwd_q <= claim_o;
  end
  assign fwd_o = fwd_q;

  // R10: every strobe is followed by a forward pulse
  assert_fwd_after_claim_R10: assert property (@(posedge clk) disable iff (rst)
    claim_o |=> fwd_o);
  // R10: no forward pulse without a strobe before it
  assert_fwd_has_claim_R10: assert property (@(posedge clk) disable iff (rst)
    fwd_o |-> $past(claim_o));
  // R2: a positive decision is only made for I/O commands
  assert_active_io_only_R2: assert property (@(posedge clk) disable iff (rst)
    (!start_n && dec.active) |-> (cmd == CMD_IO_RD || cmd == CMD_IO_WR));
endmodule

// File: tb/legacy_claim_decoder_tb.sv
module legacy_claim_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        start_n;
  logic [3:0]  cmd;
  logic [31:0] addr;
  logic [1:0]  cfg_speed;
  logic        cfg_rej_pri, cfg_rej_sec, cfg_dma_en, ext_claim;
  logic        claim_o, claim_active_o, fwd_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  legacy_claim_decoder dut_i (
    .clk(clk), .rst(rst), .start_n(start_n), .cmd(cmd), .addr(addr),
    .cfg_speed(cfg_speed), .cfg_rej_pri(cfg_rej_pri), .cfg_rej_sec(cfg_rej_sec),
    .cfg_dma_en(cfg_dma_en), .ext_claim(ext_claim), .claim_o(claim_o),
    .claim_active_o(claim_active_o), .fwd_o(fwd_o));

  // {req4, addr16, cmd4, speed2, rej_pri, rej_sec, dma_en, ext_clock3, exp_clock3, exp_active}
  localparam int NV = 23;
  localparam logic [35:0] VEC [NV] = '{
    {4'd3,  16'h0060, 4'h2, 2'b10, 3'b000, 3'd0, 3'd2, 1'b1}, // R3 medium
    {4'd4,  16'h0060, 4'h3, 2'b01, 3'b000, 3'd0, 3'd3, 1'b1}, // R4 slow
    {4'd5,  16'h0060, 4'h2, 2'b00, 3'b000, 3'd0, 3'd4, 1'b0}, // R5 default
    {4'd5,  16'h0060, 4'h2, 2'b11, 3'b000, 3'd0, 3'd4, 1'b0}, // R5 reserved
    {4'd5,  16'h0400, 4'h2, 2'b10, 3'b000, 3'd0, 3'd4, 1'b0}, // R5 above window
    {4'd2,  16'h0060, 4'h6, 2'b10, 3'b000, 3'd0, 3'd4, 1'b0}, // R2 memory read
    {4'd6,  16'h01F0, 4'h2, 2'b10, 3'b100, 3'd0, 3'd4, 1'b0}, // R6
    {4'd6,  16'h01F7, 4'h3, 2'b10, 3'b100, 3'd0, 3'd4, 1'b0}, // R6
    {4'd6,  16'h03F6, 4'h2, 2'b01, 3'b100, 3'd0, 3'd4, 1'b0}, // R6
    {4'd6,  16'h01F8, 4'h2, 2'b10, 3'b100, 3'd0, 3'd2, 1'b1}, // R6 neighbour
    {4'd6,  16'h01F0, 4'h2, 2'b10, 3'b000, 3'd0, 3'd2, 1'b1}, // R6 reject off
    {4'd7,  16'h0170, 4'h2, 2'b10, 3'b010, 3'd0, 3'd4, 1'b0}, // R7
    {4'd7,  16'h0376, 4'h2, 2'b01, 3'b010, 3'd0, 3'd4, 1'b0}, // R7
    {4'd7,  16'h0177, 4'h2, 2'b10, 3'b100, 3'd0, 3'd2, 1'b1}, // R7 primary bit only
    {4'd8,  16'h0480, 4'h2, 2'b00, 3'b001, 3'd0, 3'd2, 1'b1}, // R8
    {4'd8,  16'h048F, 4'h3, 2'b00, 3'b001, 3'd0, 3'd2, 1'b1}, // R8
    {4'd8,  16'h0490, 4'h2, 2'b00, 3'b001, 3'd0, 3'd4, 1'b0}, // R8 past end
    {4'd8,  16'h0480, 4'h2, 2'b10, 3'b000, 3'd0, 3'd4, 1'b0}, // R8 disabled
    {4'd2,  16'h0480, 4'hA, 2'b00, 3'b001, 3'd0, 3'd4, 1'b0}, // R2 config read
    {4'd9,  16'h0060, 4'h2, 2'b00, 3'b000, 3'd3, 3'd0, 1'b0}, // R9 cancel clock 3
    {4'd9,  16'h0060, 4'h2, 2'b00, 3'b000, 3'd2, 3'd0, 1'b0}, // R9 cancel clock 2
    {4'd9,  16'h0060, 4'h2, 2'b00, 3'b000, 3'd4, 3'd4, 1'b0}, // R9 too late
    {4'd9,  16'h0060, 4'h2, 2'b01, 3'b000, 3'd2, 3'd3, 1'b1}  // R9 active kept
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One transaction; clocks numbered from the address clock (1).
  task automatic run_txn(input logic [31:0] a, input logic [3:0] c, input logic [1:0] s,
                         input logic rp, input logic rs, input logic de,
                         input int ext_clk, input int restart_clk,
                         output int clm_clk, output int act, output int fwd_clk,
                         output int n_clm);
    clm_clk = 0; act = 0; fwd_clk = 0; n_clm = 0;
    cfg_speed = s; cfg_rej_pri = rp; cfg_rej_sec = rs; cfg_dma_en = de;
    for (int k = 1; k <= 9; k++) begin
      @(negedge clk);
      start_n   = !(k == 1 || k == restart_clk);
      addr      = (k == 1) ? a : 32'h0000_0060;
      cmd       = (k == 1) ? c : 4'h2;
      ext_claim = (k == ext_clk);
      if (claim_o) begin
        n_clm++;
        if (clm_clk == 0) begin clm_clk = k; act = claim_active_o; end
      end
      if (fwd_o && fwd_clk == 0) fwd_clk = k;
    end
    @(negedge clk);
    start_n = 1'b1; ext_claim = 1'b0;
  endtask

  initial begin
    int cc, ac, fc, nc;
    rst = 1'b1; start_n = 1'b1; cmd = 4'h0; addr = '0; cfg_speed = 2'b00;
    cfg_rej_pri = 1'b0; cfg_rej_sec = 1'b0; cfg_dma_en = 1'b0; ext_claim = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "claim after reset", claim_o, 0);
    check("R1", "active after reset", claim_active_o, 0);
    check("R1", "forward after reset", fwd_o, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i][35:32]);
      run_txn({16'h0, VEC[i][31:16]}, VEC[i][15:12], VEC[i][11:10], VEC[i][9],
              VEC[i][8], VEC[i][7], int'(VEC[i][6:4]), 0, cc, ac, fc, nc);
      check(tag, $sformatf("vec %0d claim clock", i), cc, int'(VEC[i][3:1]));
      check(tag, $sformatf("vec %0d active", i), ac, int'(VEC[i][0]));
      // R10: forward one clock after the claim, none when cancelled
      check("R10", $sformatf("vec %0d forward clock", i), fc,
            (VEC[i][3:1] == 0) ? 0 : int'(VEC[i][3:1]) + 1);
    end

    // R5: upper address bits keep the cycle out of the legacy window
    run_txn(32'h0001_0060, 4'h2, 2'b10, 0, 0, 0, 0, 0, cc, ac, fc, nc);
    check("R5", "high address claim clock", cc, 4);
    check("R5", "high address active", ac, 0);

    // R11: start in the claim cycle of a medium claim is ignored
    run_txn(32'h0060, 4'h2, 2'b10, 0, 0, 0, 0, 2, cc, ac, fc, nc);
    check("R11", "restart in claim cycle strobes", nc, 1);
    // R11: start while a subtractive claim is pending is ignored
    run_txn(32'h0060, 4'h2, 2'b00, 0, 0, 0, 0, 3, cc, ac, fc, nc);
    check("R11", "restart while pending strobes", nc, 1);
    check("R11", "restart while pending clock", cc, 4);

    // R1: reset in the middle of a subtractive claim kills it
    cfg_speed = 2'b00;
    @(negedge clk); start_n = 1'b0; addr = 32'h60; cmd = 4'h2;
    @(negedge clk); start_n = 1'b1; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    nc = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (claim_o || fwd_o) nc++;
    end
    check("R1", "outputs after mid-transaction reset", nc, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule